// File: doc/BRIEF.md
# Electronic Load Protection Sequencer

This block decides how an electronic load reacts to its protection comparators. It receives one-bit trip flags: reverse energy at the input, critical over-temperature, safe-operating-area violation, over-power, over-current, over-voltage and a heatsink temperature warning. From these it moves the load through four policy states: normal, warning, foldback and shutdown. It drives a gate-command enable, a scale factor that throttles the current and power setpoint, a clamp or disconnect control for reverse energy, and a 3-bit code that names the cause.

When several trips are present at once, a fixed priority picks the cause that is reported. Reverse energy and critical over-temperature are terminal. They remove the command at once and latch the load off. The load comes back only after a tick-based cooldown has run out with every critical flag clear and a clear request has been accepted. Area, power and current trips are not terminal. They step the scale factor down on each tick down to a floor. Once the trip has been gone for a hysteresis period, the scale steps back up to full. The time base is an external tick strobe.

Top module: `eload_prot_seq`

## Requirements
- R1: After reset, state_o is 0 (normal), cmd_en is 1, scale is all ones, fault_code is 0 and rev_clamp and rev_disc are 0.
- R2: Outside shutdown, fault_code shows the highest-priority active trip one clock after the trip is sampled. The codes are 1 reverse, 2 critical over-temperature, 3 area violation, 4 over-power, 5 over-current, 6 over-voltage and 0 none. A lower number wins. A heatsink warning carries code 0.
- R3: An over-voltage or heatsink warning with no higher trip moves the state to warning (state_o 1) two clocks after it is applied. The state returns to normal (0) two clocks after the warning clears.
- R4: An area, over-power or over-current trip moves the state to foldback (state_o 2). While the trip persists, each tick lowers scale by FOLD_STEP, and scale never goes below FOLD_MIN.
- R5: Once the trip has been clear for HYST_TICKS ticks, each further tick raises scale by FOLD_STEP, capped at all ones. A trip that returns first restarts the hysteresis count. One clock after scale reaches full with no trip, the state leaves foldback.
- R6: A reverse or critical over-temperature trip drops cmd_en one clock after the trip is applied. The state becomes shutdown (state_o 3) on the next clock. In shutdown, scale reads 0 and cmd_en stays 0.
- R7: In shutdown, fault_code holds the cause captured on entry, even after the trips clear.
- R8: Cooldown needs COOL_TICKS ticks with no critical trip. A critical trip during shutdown restarts the cooldown.
- R9: A clear request takes the state from shutdown to normal only if the cooldown has expired and no critical trip is present. In any other case the request is ignored and the state stays 3.
- R10: With REV_DISCONNECT=0, rev_clamp follows the reverse trip one clock after it is applied, and rev_disc stays 0.
- R11: With REV_DISCONNECT=1, rev_disc rises one clock after a reverse trip and stays high until a clear request is accepted. rev_clamp stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Time-base strobe for foldback and cooldown |
| rev_trip | input | 1 | Reverse voltage or current detected |
| otp_crit | input | 1 | Critical over-temperature |
| soa_trip | input | 1 | Safe-operating-area violation |
| opp_trip | input | 1 | Over-power |
| ocp_trip | input | 1 | Over-current |
| ovp_trip | input | 1 | Input over-voltage |
| sink_warn | input | 1 | Heatsink temperature warning |
| clr_req | input | 1 | Request to leave shutdown |
| cmd_en | output | 1 | Gate command enable |
| scale | output | SCALE_W | Setpoint scale factor, all ones = full |
| fault_code | output | 3 | Cause code |
| state_o | output | 2 | Policy state: 0 normal, 1 warning, 2 foldback, 3 shutdown |
| rev_clamp | output | 1 | Reverse clamp control |
| rev_disc | output | 1 | Reverse disconnect control |

## Verification
The bench builds two copies: one with the clamp variant and one with the disconnect variant. Both use an 8-bit scale with a step and floor of 64, a hysteresis of 2 ticks and a cooldown of 4 ticks. With these values the whole descent to the floor, the restart of the hysteresis count and the full recovery to all ones take only a few ticks. It also makes a clear request one tick short of cooldown distinguishable from one that arrives on time, and lets a critical trip that returns mid-cooldown be seen to restart the count.

// File: rtl/eload_prot_pkg.sv
package eload_prot_pkg;

   typedef enum logic [1:0] {
      ST_NORMAL = 2'd0,
      ST_WARN   = 2'd1,
      ST_FOLD   = 2'd2,
      ST_SHUT   = 2'd3
   } prot_state_e;

   // cause vector bit i reports code i+1; lower index = higher priority
   localparam int NUM_CAUSE = 6;
   localparam int CODE_W    = $clog2(NUM_CAUSE + 1);

   localparam int IDX_REV = 0;
   localparam int IDX_OTP = 1;
   localparam int IDX_SOA = 2;
   localparam int IDX_OPP = 3;
   localparam int IDX_OCP = 4;
   localparam int IDX_OVP = 5;

endpackage

// File: rtl/prot_prio_enc.sv
module prot_prio_enc #(
   parameter int N  = 6,
   parameter int CW = 3
) (
   input  logic [N-1:0]  act,
   output logic [CW-1:0] code
);
   if (CW < $clog2(N + 1)) begin : g_chk_cw
      $error("prot_prio_enc: CW too narrow for N causes");
   end

   // scan from lowest priority upward so the highest active cause is written last
   always_comb begin
      code = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (act[i]) code = CW'(i + 1);
      end
   end
endmodule

// File: rtl/prot_fold_scale.sv
module prot_fold_scale #(
   parameter int SCALE_W    = 8,
   parameter int FOLD_STEP  = 16,
   parameter int FOLD_MIN   = 32,
   parameter int HYST_TICKS = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               fold_active,
   input  logic               cause,
   output logic [SCALE_W-1:0] scale_q,
   output logic               at_full
);
   localparam int                 HYST_W = $clog2(HYST_TICKS + 1);
   localparam logic [SCALE_W-1:0] FULL   = '1;
   localparam logic [SCALE_W:0]   STEP_X = (SCALE_W + 1)'(FOLD_STEP);
   localparam logic [SCALE_W:0]   MIN_X  = (SCALE_W + 1)'(FOLD_MIN);
   localparam logic [SCALE_W:0]   FULL_X = {1'b0, FULL};

   if (FOLD_STEP < 1 || FOLD_STEP > (1 << SCALE_W) - 1) begin : g_chk_step
      $error("prot_fold_scale: FOLD_STEP out of range");
   end
   if (FOLD_MIN < 0 || FOLD_MIN >= (1 << SCALE_W) - 1) begin : g_chk_min
      $error("prot_fold_scale: FOLD_MIN out of range");
   end
   if (HYST_TICKS < 1) begin : g_chk_hyst
      $error("prot_fold_scale: HYST_TICKS must be at least 1");
   end

   logic [HYST_W-1:0] hcnt_q;
   logic [SCALE_W:0]  ext;
   logic [SCALE_W:0]  headroom;

   assign ext      = {1'b0, scale_q};
   assign headroom = FULL_X - ext;
   assign at_full  = (scale_q == FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scale_q <= FULL;
         hcnt_q  <= '0;
      end else if (!fold_active) begin
         scale_q <= FULL;
         hcnt_q  <= '0;
      end else if (cause) begin
         hcnt_q <= '0;
         if (tick) begin
            if (ext >= MIN_X + STEP_X) scale_q <= scale_q - STEP_X[SCALE_W-1:0];
            else                       scale_q <= MIN_X[SCALE_W-1:0];
         end
      end else if (tick) begin
         if (hcnt_q < HYST_W'(HYST_TICKS)) begin
            hcnt_q <= hcnt_q + 1'b1;
         end else if (headroom <= STEP_X) begin
            scale_q <= FULL;
         end else begin
            scale_q <= scale_q + STEP_X[SCALE_W-1:0];
         end
      end
   end

   // R5: while the cause persists the scale can only fall or hold
   p_no_rise_under_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fold_active && cause) |=> (!fold_active || scale_q <= $past(scale_q)));

   // R4: foldback never drives the scale beneath its floor
   p_scale_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fold_active |-> ({1'b0, scale_q} >= MIN_X));
endmodule

// File: rtl/prot_cooldown.sv
module prot_cooldown #(
   parameter int COOL_TICKS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic in_shut,
   input  logic crit,
   output logic done
);
   localparam int COOL_W = $clog2(COOL_TICKS + 1);

   if (COOL_TICKS < 1) begin : g_chk_cool
      $error("prot_cooldown: COOL_TICKS must be at least 1");
   end

   logic [COOL_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= COOL_W'(COOL_TICKS);
      else if (!in_shut || crit)      cnt_q <= COOL_W'(COOL_TICKS);
      else if (tick && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

   // R8: with no critical cause in shutdown the count never climbs
   p_cool_monotone_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_shut && !crit) |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/eload_prot_seq.sv
module eload_prot_seq
   import eload_prot_pkg::*;
#(
   parameter int SCALE_W        = 8,
   parameter int FOLD_STEP      = 16,
   parameter int FOLD_MIN       = 32,
   parameter int HYST_TICKS     = 4,
   parameter int COOL_TICKS     = 16,
   parameter bit REV_DISCONNECT = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               rev_trip,
   input  logic               otp_crit,
   input  logic               soa_trip,
   input  logic               opp_trip,
   input  logic               ocp_trip,
   input  logic               ovp_trip,
   input  logic               sink_warn,
   input  logic               clr_req,
   output logic               cmd_en,
   output logic [SCALE_W-1:0] scale,
   output logic [2:0]         fault_code,
   output logic [1:0]         state_o,
   output logic               rev_clamp,
   output logic               rev_disc
);
   if (CODE_W != 3) begin : g_chk_code
      $error("eload_prot_seq: cause code must be 3 bits");
   end

   // registered trip flags
   logic [NUM_CAUSE-1:0] cause_q;
   logic                 warn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_q <= '0;
         warn_q  <= 1'b0;
      end else begin
         cause_q[IDX_REV] <= rev_trip;
         cause_q[IDX_OTP] <= otp_crit;
         cause_q[IDX_SOA] <= soa_trip;
         cause_q[IDX_OPP] <= opp_trip;
         cause_q[IDX_OCP] <= ocp_trip;
         cause_q[IDX_OVP] <= ovp_trip;
         warn_q           <= sink_warn;
      end
   end

   logic crit, fold_cause, warn_cause;
   assign crit       = cause_q[IDX_REV] | cause_q[IDX_OTP];
   assign fold_cause = cause_q[IDX_SOA] | cause_q[IDX_OPP] | cause_q[IDX_OCP];
   assign warn_cause = cause_q[IDX_OVP] | warn_q;

   logic [CODE_W-1:0] live_code;
   prot_prio_enc #(.N(NUM_CAUSE), .CW(CODE_W)) u_prio (
      .act  (cause_q),
      .code (live_code)
   );

   prot_state_e state_q, state_d;
   logic        cool_done;
   logic        release_ok;
   logic        at_full;
   logic [SCALE_W-1:0] scale_q;

   assign release_ok = (state_q == ST_SHUT) && clr_req && cool_done && !crit;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_NORMAL: begin
            if (crit)            state_d = ST_SHUT;
            else if (fold_cause) state_d = ST_FOLD;
            else if (warn_cause) state_d = ST_WARN;
         end
         ST_WARN: begin
            if (crit)            state_d = ST_SHUT;
            else if (fold_cause) state_d = ST_FOLD;
            else if (!warn_cause) state_d = ST_NORMAL;
         end
         ST_FOLD: begin
            if (crit)                      state_d = ST_SHUT;
            else if (!fold_cause && at_full) state_d = warn_cause ? ST_WARN : ST_NORMAL;
         end
         ST_SHUT: begin
            if (release_ok)      state_d = ST_NORMAL;
         end
         default:                state_d = ST_NORMAL;
      endcase
   end

   logic [CODE_W-1:0] code_lat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_NORMAL;
         code_lat_q <= '0;
      end else begin
         state_q <= state_d;
         if (state_q != ST_SHUT && state_d == ST_SHUT) code_lat_q <= live_code;
      end
   end

   prot_fold_scale #(
      .SCALE_W    (SCALE_W),
      .FOLD_STEP  (FOLD_STEP),
      .FOLD_MIN   (FOLD_MIN),
      .HYST_TICKS (HYST_TICKS)
   ) u_fold (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .fold_active (state_q == ST_FOLD),
      .cause       (fold_cause),
      .scale_q     (scale_q),
      .at_full     (at_full)
   );

   prot_cooldown #(.COOL_TICKS(COOL_TICKS)) u_cool (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .in_shut (state_q == ST_SHUT),
      .crit    (crit),
      .done    (cool_done)
   );

   // reverse-energy action variant
   if (REV_DISCONNECT) begin : g_rev_disc
      logic hold_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 hold_q <= 1'b0;
         else if (cause_q[IDX_REV])  hold_q <= 1'b1;
         else if (release_ok)        hold_q <= 1'b0;
      end
      assign rev_disc  = cause_q[IDX_REV] | hold_q;
      assign rev_clamp = 1'b0;

      // R11: the disconnect stays open until a clear is accepted
      p_disc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (rev_disc && !release_ok) |=> rev_disc);
   end else begin : g_rev_clamp
      assign rev_clamp = cause_q[IDX_REV];
      assign rev_disc  = 1'b0;
   end

   assign cmd_en     = (state_q != ST_SHUT) && !crit;
   assign scale      = (state_q == ST_SHUT) ? '0 : scale_q;
   assign fault_code = (state_q == ST_SHUT) ? code_lat_q : live_code;
   assign state_o    = state_q;

   // R6: no command while shut down
   p_shut_no_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SHUT) |-> (!cmd_en && scale == '0));

   // R9: leaving shutdown only after the cooldown ran out
   p_exit_cooled_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_q) == ST_SHUT && state_q != ST_SHUT) |-> $past(cool_done));

   // R7: the reported cause is frozen during shutdown
   p_code_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_q) == ST_SHUT && state_q == ST_SHUT) |-> $stable(fault_code));
endmodule

// File: tb/tb_eload_prot_seq.sv
module tb_eload_prot_seq;
   localparam int SW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 0, rev_trip = 0, otp_crit = 0, soa_trip = 0, opp_trip = 0;
   logic ocp_trip = 0, ovp_trip = 0, sink_warn = 0, clr_req = 0;

   logic          cmd_en, rev_clamp, rev_disc;
   logic [SW-1:0] scale;
   logic [2:0]    fault_code;
   logic [1:0]    state_o;
   logic          cmd_en2, rev_clamp2, rev_disc2;
   logic [SW-1:0] scale2;
   logic [2:0]    fault_code2;
   logic [1:0]    state_o2;

   always #4 clk = ~clk;

   eload_prot_seq #(.SCALE_W(SW), .FOLD_STEP(64), .FOLD_MIN(64), .HYST_TICKS(2),
                    .COOL_TICKS(4), .REV_DISCONNECT(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rev_trip(rev_trip), .otp_crit(otp_crit),
      .soa_trip(soa_trip), .opp_trip(opp_trip), .ocp_trip(ocp_trip), .ovp_trip(ovp_trip),
      .sink_warn(sink_warn), .clr_req(clr_req), .cmd_en(cmd_en), .scale(scale),
      .fault_code(fault_code), .state_o(state_o), .rev_clamp(rev_clamp), .rev_disc(rev_disc));

   eload_prot_seq #(.SCALE_W(SW), .FOLD_STEP(64), .FOLD_MIN(64), .HYST_TICKS(2),
                    .COOL_TICKS(4), .REV_DISCONNECT(1'b1)) dut_dc (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rev_trip(rev_trip), .otp_crit(otp_crit),
      .soa_trip(soa_trip), .opp_trip(opp_trip), .ocp_trip(ocp_trip), .ovp_trip(ovp_trip),
      .sink_warn(sink_warn), .clr_req(clr_req), .cmd_en(cmd_en2), .scale(scale2),
      .fault_code(fault_code2), .state_o(state_o2), .rev_clamp(rev_clamp2), .rev_disc(rev_disc2));

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   // {faults: warn,ovp,ocp,opp,soa,otp,rev}, expected code, expected state
   localparam logic [11:0] VEC [10] = '{
      {7'b0000100, 3'd3, 2'd2},
      {7'b0001000, 3'd4, 2'd2},
      {7'b0010000, 3'd5, 2'd2},
      {7'b0100000, 3'd6, 2'd1},
      {7'b1000000, 3'd0, 2'd1},
      {7'b0111100, 3'd3, 2'd2},
      {7'b0011000, 3'd4, 2'd2},
      {7'b1110000, 3'd5, 2'd2},
      {7'b1100000, 3'd6, 2'd1},
      {7'b0000000, 3'd0, 2'd0}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic apply(input logic [6:0] f);
      {sink_warn, ovp_trip, ocp_trip, opp_trip, soa_trip, otp_crit, rev_trip} = f;
   endtask

   task automatic pulse_tick();
      tick = 1'b1; edges(1); tick = 1'b0;
   endtask

   task automatic pulse_clr();
      clr_req = 1'b1; edges(1); clr_req = 1'b0;
   endtask

   initial begin
      edges(3);
      rst_n = 1'b1;
      edges(1);
      // R1 reset state
      chk("R1 state", state_o, 0);
      chk("R1 cmd_en", cmd_en, 1);
      chk("R1 scale", scale, 255);
      chk("R1 code", fault_code, 0);
      chk("R1 clamp", rev_clamp, 0);
      chk("R1 disc", rev_disc2, 0);

      // R2 / R3 / R4 priority and state table
      foreach (VEC[i]) begin
         apply(VEC[i][11:5]);
         edges(1);
         chk("R2 code", fault_code, int'(VEC[i][4:2]));
         chk("R2 cmd_en", cmd_en, 1);
         edges(1);
         chk("R3_R4 state", state_o, int'(VEC[i][1:0]));
         apply(7'd0);
         edges(2);
         chk("R3 back to normal", state_o, 0);
      end

      // R4 foldback descent to the floor
      opp_trip = 1'b1;
      edges(2);
      chk("R4 fold state", state_o, 2);
      pulse_tick(); chk("R4 step1", scale, 191);
      pulse_tick(); chk("R4 step2", scale, 127);
      pulse_tick(); chk("R4 floor", scale, 64);
      pulse_tick(); chk("R4 floor hold", scale, 64);

      // R5 hysteresis with a returning cause
      opp_trip = 1'b0; edges(1);
      pulse_tick(); chk("R5 hyst1", scale, 64);
      opp_trip = 1'b1; edges(1);
      opp_trip = 1'b0; edges(1);
      pulse_tick(); chk("R5 restart1", scale, 64);
      pulse_tick(); chk("R5 restart2", scale, 64);
      pulse_tick(); chk("R5 up1", scale, 128);
      pulse_tick(); chk("R5 up2", scale, 192);
      pulse_tick(); chk("R5 full", scale, 255);
      chk("R5 still fold", state_o, 2);
      edges(1);
      chk("R5 exit fold", state_o, 0);

      // R6 critical over-temperature
      otp_crit = 1'b1;
      edges(1);
      chk("R6 cmd_en cut", cmd_en, 0);
      chk("R6 state not yet", state_o, 0);
      chk("R2 otp code", fault_code, 2);
      edges(1);
      chk("R6 shut", state_o, 3);
      chk("R6 scale zero", scale, 0);

      // R9 clear ignored while critical present
      pulse_clr();
      chk("R9 ignored crit", state_o, 3);
      otp_crit = 1'b0; edges(1);
      chk("R7 code held", fault_code, 2);
      // R8 restart on reassert
      pulse_tick(); pulse_tick();
      otp_crit = 1'b1; edges(1);
      otp_crit = 1'b0; edges(1);
      pulse_tick(); pulse_tick(); pulse_tick();
      pulse_clr();
      chk("R8 R9 early clear ignored", state_o, 3);
      chk("R6 cmd off in shut", cmd_en, 0);
      pulse_tick();
      pulse_clr();
      chk("R9 released", state_o, 0);
      chk("R9 cmd_en back", cmd_en, 1);
      chk("R9 code cleared", fault_code, 0);
      chk("R9 scale full", scale, 255);

      // R10 / R11 reverse energy with priority over OTP
      rev_trip = 1'b1; otp_crit = 1'b1;
      edges(1);
      chk("R2 rev wins", fault_code, 1);
      chk("R10 clamp on", rev_clamp, 1);
      chk("R10 no disc", rev_disc, 0);
      chk("R11 disc on", rev_disc2, 1);
      chk("R11 no clamp", rev_clamp2, 0);
      edges(1);
      chk("R6 rev shut", state_o, 3);
      rev_trip = 1'b0; otp_crit = 1'b0;
      edges(1);
      chk("R10 clamp off", rev_clamp, 0);
      chk("R11 disc held", rev_disc2, 1);
      chk("R7 rev code held", fault_code, 1);
      repeat (4) pulse_tick();
      chk("R11 disc held cooled", rev_disc2, 1);
      pulse_clr();
      chk("R11 disc released", rev_disc2, 0);
      chk("R11 dc state", state_o2, 0);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #200000;
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule